// File: doc/BRIEF.md
# Prefixed Instruction Length Decoder

This block walks a stream of 16-bit parcels of unblocked code, one parcel per accepted handshake, and tags every parcel. It marks where each instruction begins, what sort of instruction it is and how many parcels it spans. Parcels that continue an instruction already tagged are marked as continuations. A front end uses these tags to cut the stream into instructions before opcode decode.

Three prefix forms are recognised. The first is a run prefix that opens a sequence of 16-bit instructions. The second is a general prefix whose fields size an optional supplementary part and up to two immediates. The third is a short prefix that carries an 8-bit immediate in itself. Any other parcel starts a plain 32-bit instruction. Malformed prefixes raise an error tag on their own parcel. Run members are tagged as instruction starts, but not as legal branch entries.

The result for a parcel is registered, and appears the cycle after the parcel is accepted. A downstream stall holds the result and blocks the input.

Top module: `prefix_len_decoder`

## Requirements
- R1: A parcel is taken when `in_valid_i` and `in_ready_o` are both high. `in_ready_o` equals `!out_valid_o || out_ready_i`. The tag for a taken parcel shows on the outputs one cycle later, and it holds unchanged while `out_ready_i` is low.
- R2: A parcel decoded fresh whose bits [15:12] are not 4'hF opens a plain instruction. It is tagged start=1, entry=1, kind=0, len=2, err=0, and the next parcel is its continuation.
- R3: A parcel decoded fresh with [15:12]=4'hF and [11:10]=2'b00 is a run prefix with count [7:0]. It is tagged kind=1, len=1, entry=1. The next `count` parcels are each tagged start=1, entry=0, kind=2, len=1, and are never decoded as prefixes.
- R4: A run prefix with count 0 sets err=1 and opens no run members.
- R5: A parcel with [15:12]=4'hF and [11:10]=2'b01 is a general prefix, tagged kind=3. Its supplementary length is in [8:6] (in parcels), the first immediate code is in [5:3] and the second in [2:0]. Its len is 3 + supplementary length + parcels of both immediates. Immediate code 0 means the immediate is absent. Codes 1 and 2 take 1 parcel, and codes 3, 4, 5 and 6 take 2, 4, 8 and 16 parcels.
- R6: When both immediate codes are 1, the two bytes share one parcel, so the immediates add 1 to len.
- R7: An immediate code of 7 sets err=1, and that immediate adds nothing to len.
- R8: A parcel with [15:12]=4'hF and [11:10]=2'b10 is a short-immediate prefix, tagged kind=4, len=3, err=0.
- R9: A parcel with [15:12]=4'hF and [11:10]=2'b11 is tagged kind=6, len=1, err=1.
- R10: Every parcel after the first one of an instruction is tagged start=0, entry=0, kind=5, len=0, err=0.
- R11: While `rst_ni` is low, `out_valid_o` is 0. The first parcel after reset is decoded fresh, whatever instruction or run was open before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Parcel present |
| in_ready_o | output | 1 | Parcel can be taken |
| parcel_i | input | 16 | Code parcel |
| out_valid_o | output | 1 | Tag present |
| out_ready_i | input | 1 | Tag consumed |
| start_o | output | 1 | Parcel begins an instruction |
| entry_o | output | 1 | Parcel is a legal branch entry |
| kind_o | output | 3 | Parcel kind (0 plain, 1 run prefix, 2 run member, 3 general, 4 short, 5 continuation, 6 reserved) |
| len_o | output | LEN_W (6) | Instruction length in parcels, 0 on continuations |
| err_o | output | 1 | Malformed prefix |

## Verification
The assertions assume that `in_valid_i`, `out_ready_i` and `parcel_i` carry known values on every clock edge after reset. They also assume that nothing downstream relies on a tag beyond the cycle in which it is consumed. The stimulus meets this by changing every input only on the falling edge, and by never leaving an input undriven once reset is released. Random parcels are pushed mostly with the prefix nibble forced. This lets long general instructions, zero-count runs and reserved codes appear without breaking the assumption that every 16-bit pattern is a legal input.

// File: rtl/lendec_pkg.sv
package lendec_pkg;
  localparam int PARCEL_W = 16;

  typedef enum logic [2:0] {
    K_BASE   = 3'd0,
    K_RUN    = 3'd1,
    K_MEMBER = 3'd2,
    K_GEN    = 3'd3,
    K_SHORT  = 3'd4,
    K_CONT   = 3'd5,
    K_BAD    = 3'd6
  } kind_e;

  // parcels taken by one immediate; code 7 is illegal and counts as absent
  function automatic logic [5:0] imm_parcels(input logic [2:0] code);
    case (code)
      3'd1, 3'd2: imm_parcels = 6'd1;
      3'd3:       imm_parcels = 6'd2;
      3'd4:       imm_parcels = 6'd4;
      3'd5:       imm_parcels = 6'd8;
      3'd6:       imm_parcels = 6'd16;
      default:    imm_parcels = 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/lendec_classify.sv
module lendec_classify
  import lendec_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int RUN_W = 8
) (
  input  logic [PARCEL_W-1:0] parcel_i,
  output kind_e               kind_o,
  output logic [LEN_W-1:0]    len_o,
  output logic                err_o,
  output logic [RUN_W-1:0]    run_cnt_o
);
  localparam int N_IMM = 2;

  logic [2:0] code [N_IMM];
  logic [5:0] ipar [N_IMM];
  logic [5:0] imm_sum;
  logic       bad_code;

  assign code[0] = parcel_i[5:3];
  assign code[1] = parcel_i[2:0];

  for (genvar g = 0; g < N_IMM; g++) begin : g_imm
    assign ipar[g] = imm_parcels(code[g]);
  end

  // two byte immediates pack into one parcel
  assign imm_sum  = (code[0] == 3'd1 && code[1] == 3'd1) ? 6'd1 : ipar[0] + ipar[1];
  assign bad_code = (code[0] == 3'd7) || (code[1] == 3'd7);

  always_comb begin
    kind_o    = K_BASE;
    len_o     = LEN_W'(2);
    err_o     = 1'b0;
    run_cnt_o = '0;
    if (parcel_i[15:12] == 4'hF) begin
      case (parcel_i[11:10])
        2'b00: begin
          kind_o    = K_RUN;
          len_o     = LEN_W'(1);
          run_cnt_o = RUN_W'(parcel_i[7:0]);
          err_o     = (parcel_i[7:0] == 8'd0);
        end
        2'b01: begin
          kind_o = K_GEN;
          len_o  = LEN_W'(3) + LEN_W'(parcel_i[8:6]) + LEN_W'(imm_sum);
          err_o  = bad_code;
        end
        2'b10: begin
          kind_o = K_SHORT;
          len_o  = LEN_W'(3);
        end
        default: begin
          kind_o = K_BAD;
          len_o  = LEN_W'(1);
          err_o  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/lendec_track.sv
module lendec_track
  import lendec_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int RUN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             out_ready_i,
  input  kind_e            cls_kind_i,
  input  logic [LEN_W-1:0] cls_len_i,
  input  logic             cls_err_i,
  input  logic [RUN_W-1:0] cls_run_i,
  output logic             out_valid_o,
  output logic             start_o,
  output logic             entry_o,
  output kind_e            kind_o,
  output logic [LEN_W-1:0] len_o,
  output logic             err_o
);
  logic [LEN_W-1:0] rem_q;
  logic [RUN_W-1:0] run_q;
  logic             take;
  logic             n_start, n_entry, n_err;
  kind_e            n_kind;
  logic [LEN_W-1:0] n_len;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  always_comb begin
    n_start = 1'b0;
    n_entry = 1'b0;
    n_kind  = K_CONT;
    n_len   = '0;
    n_err   = 1'b0;
    if (rem_q != '0) begin
      n_kind = K_CONT;
    end else if (run_q != '0) begin
      n_start = 1'b1;
      n_kind  = K_MEMBER;
      n_len   = LEN_W'(1);
    end else begin
      n_start = 1'b1;
      n_entry = 1'b1;
      n_kind  = cls_kind_i;
      n_len   = cls_len_i;
      n_err   = cls_err_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q       <= '0;
      run_q       <= '0;
      out_valid_o <= 1'b0;
      start_o     <= 1'b0;
      entry_o     <= 1'b0;
      kind_o      <= K_BASE;
      len_o       <= '0;
      err_o       <= 1'b0;
    end else if (take) begin
      out_valid_o <= 1'b1;
      start_o     <= n_start;
      entry_o     <= n_entry;
      kind_o      <= n_kind;
      len_o       <= n_len;
      err_o       <= n_err;
      if (rem_q != '0)      rem_q <= rem_q - 1'b1;
      else if (run_q != '0) run_q <= run_q - 1'b1;
      else begin
        rem_q <= cls_len_i - 1'b1;
        run_q <= (cls_kind_i == K_RUN) ? cls_run_i : '0;
      end
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(kind_o) && $stable(len_o) && $stable(start_o));

  p_member_noentry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && kind_o == K_MEMBER |-> start_o && !entry_o && len_o == LEN_W'(1));

  p_cont_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !start_o |-> kind_o == K_CONT && len_o == '0 && !err_o && !entry_o);

  p_gen_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && kind_o == K_GEN |-> len_o >= LEN_W'(3));

  p_short_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && kind_o == K_SHORT |-> len_o == LEN_W'(3) && !err_o && entry_o);
endmodule

// File: rtl/prefix_len_decoder.sv
module prefix_len_decoder
  import lendec_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int RUN_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [PARCEL_W-1:0] parcel_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic                start_o,
  output logic                entry_o,
  output logic [2:0]          kind_o,
  output logic [LEN_W-1:0]    len_o,
  output logic                err_o
);
  kind_e            cls_kind, trk_kind;
  logic [LEN_W-1:0] cls_len;
  logic             cls_err;
  logic [RUN_W-1:0] cls_run;

  lendec_classify #(.LEN_W(LEN_W), .RUN_W(RUN_W)) i_classify (
    .parcel_i  (parcel_i),
    .kind_o    (cls_kind),
    .len_o     (cls_len),
    .err_o     (cls_err),
    .run_cnt_o (cls_run)
  );

  lendec_track #(.LEN_W(LEN_W), .RUN_W(RUN_W)) i_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .out_ready_i (out_ready_i),
    .cls_kind_i  (cls_kind),
    .cls_len_i   (cls_len),
    .cls_err_i   (cls_err),
    .cls_run_i   (cls_run),
    .out_valid_o (out_valid_o),
    .start_o     (start_o),
    .entry_o     (entry_o),
    .kind_o      (trk_kind),
    .len_o       (len_o),
    .err_o       (err_o)
  );

  assign kind_o = trk_kind;
endmodule

// File: tb/test_prefix_len_decoder.sv
`timescale 1ns/1ps
module test_prefix_len_decoder;
  localparam int LEN_W = 6;
  localparam int N_TBL = 38;
  // expected tag = {start, entry, kind[2:0], len[5:0], err}
  localparam logic [11:0] CT = {1'b0, 1'b0, 3'd5, 6'd0, 1'b0};

  localparam logic [27:0] TBL [N_TBL] = '{
    {16'h1234, 1'b1, 1'b1, 3'd0, 6'd2, 1'b0},   // R2 plain
    {16'h5678, CT},
    {16'hF002, 1'b1, 1'b1, 3'd1, 6'd1, 1'b0},   // R3 run of 2
    {16'hFFFF, 1'b1, 1'b0, 3'd2, 6'd1, 1'b0},
    {16'h0000, 1'b1, 1'b0, 3'd2, 6'd1, 1'b0},
    {16'hF000, 1'b1, 1'b1, 3'd1, 6'd1, 1'b1},   // R4 zero count
    {16'hF409, 1'b1, 1'b1, 3'd3, 6'd4, 1'b0},   // R6 shared byte parcel
    {16'hAAAA, CT}, {16'hBBBB, CT}, {16'hCCCC, CT},
    {16'hF493, 1'b1, 1'b1, 3'd3, 6'd8, 1'b0},   // R5 supp 2, 16b, 32b
    {16'h1111, CT}, {16'h1112, CT}, {16'h1113, CT}, {16'h1114, CT},
    {16'h1115, CT}, {16'h1116, CT}, {16'h1117, CT},
    {16'hF855, 1'b1, 1'b1, 3'd4, 6'd3, 1'b0},   // R8
    {16'hF800, CT}, {16'hFC00, CT},             // R10 prefixes inside are data
    {16'hF438, 1'b1, 1'b1, 3'd3, 6'd3, 1'b1},   // R7
    {16'h0001, CT}, {16'h0002, CT},
    {16'hFC00, 1'b1, 1'b1, 3'd6, 6'd1, 1'b1},   // R9
    {16'hF401, 1'b1, 1'b1, 3'd3, 6'd4, 1'b0},   // R5 lone byte immediate
    {16'h0003, CT}, {16'h0004, CT}, {16'h0005, CT},
    {16'hF40A, 1'b1, 1'b1, 3'd3, 6'd5, 1'b0},   // R6 not shared with 16b
    {16'h0006, CT}, {16'h0007, CT}, {16'h0008, CT}, {16'h0009, CT},
    {16'hF001, 1'b1, 1'b1, 3'd1, 6'd1, 1'b0},   // R3 run of 1
    {16'hF409, 1'b1, 1'b0, 3'd2, 6'd1, 1'b0},   // R3 member not decoded
    {16'h2222, 1'b1, 1'b1, 3'd0, 6'd2, 1'b0},
    {16'h3333, CT}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid_i = 1'b0;
  logic             in_ready_o;
  logic [15:0]      parcel_i = '0;
  logic             out_valid_o;
  logic             out_ready_i = 1'b1;
  logic             start_o, entry_o, err_o;
  logic [2:0]       kind_o;
  logic [LEN_W-1:0] len_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int m_rem = 0;
  int m_run = 0;

  always #2.5 clk_i = ~clk_i;

  prefix_len_decoder #(.LEN_W(LEN_W)) i_prefix_len_decoder (.*);

  function automatic string tag_of(logic [11:0] e);
    case (e[9:7])
      3'd0: return "R2";
      3'd1: return e[0] ? "R4" : "R3";
      3'd2: return "R3";
      3'd3: return e[0] ? "R7" : "R5";
      3'd4: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [11:0] got, logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [11:0] got_tag();
    return {start_o, entry_o, kind_o, len_o, err_o};
  endfunction

  function automatic int ipar(int c);
    case (c)
      1, 2: return 1;
      3: return 2;
      4: return 4;
      5: return 8;
      6: return 16;
      default: return 0;
    endcase
  endfunction

  // independent model built from R2..R10
  function automatic logic [11:0] model(logic [15:0] p);
    int a, b, s, im;
    if (m_rem > 0) begin
      m_rem--;
      return CT;
    end
    if (m_run > 0) begin
      m_run--;
      return {1'b1, 1'b0, 3'd2, 6'd1, 1'b0};
    end
    if (p[15:12] != 4'hF) begin
      m_rem = 1;
      return {1'b1, 1'b1, 3'd0, 6'd2, 1'b0};
    end
    case (p[11:10])
      2'b00: begin
        m_run = int'(p[7:0]);
        return {1'b1, 1'b1, 3'd1, 6'd1, p[7:0] == 8'd0};
      end
      2'b01: begin
        s = int'(p[8:6]); a = int'(p[5:3]); b = int'(p[2:0]);
        im = (a == 1 && b == 1) ? 1 : ipar(a) + ipar(b);
        m_rem = 2 + s + im;
        return {1'b1, 1'b1, 3'd3, 6'(3 + s + im), (a == 7 || b == 7)};
      end
      2'b10: begin
        m_rem = 2;
        return {1'b1, 1'b1, 3'd4, 6'd3, 1'b0};
      end
      default: return {1'b1, 1'b1, 3'd6, 6'd1, 1'b1};
    endcase
  endfunction

  task automatic push(logic [15:0] p);
    in_valid_i = 1'b1;
    parcel_i   = p;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    @(negedge clk_i);
    check("R11", {11'd0, out_valid_o}, 12'd0);
    rst_ni = 1'b1;
    m_rem = 0;
    m_run = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk_i);
    do_reset();
    for (int i = 0; i < N_TBL; i++) begin
      push(TBL[i][27:12]);
      check(tag_of(TBL[i][11:0]), got_tag(), TBL[i][11:0]);
    end

    // R1: stall holds the tag and blocks input
    do_reset();
    push(16'h1234);
    out_ready_i = 1'b0;
    parcel_i = 16'h5678;
    @(negedge clk_i);
    check("R1", {got_tag()}, {1'b1, 1'b1, 3'd0, 6'd2, 1'b0});
    check("R1", {10'd0, in_ready_o, out_valid_o}, 12'd1);
    out_ready_i = 1'b1;
    @(negedge clk_i);
    check("R1", got_tag(), CT);
    in_valid_i = 1'b0;
    @(negedge clk_i);
    check("R1", {11'd0, out_valid_o}, 12'd0);

    // R11: reset inside an open run
    push(16'hF005);
    push(16'h0000);
    do_reset();
    push(16'hF409);
    check("R11", got_tag(), {1'b1, 1'b1, 3'd3, 6'd4, 1'b0});

    // random streams against the model
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] p;
      logic [11:0] e;
      p = 16'($urandom);
      if ($urandom_range(0, 3) != 0) p[15:12] = 4'hF;
      if (p[15:10] == 6'b111100) p[7:0] = 8'($urandom_range(0, 6));
      e = model(p);
      push(p);
      check(tag_of(e), got_tag(), e);
    end
    in_valid_i = 1'b0;
    @(negedge clk_i);
    finish_run();
  end
endmodule